// File: doc/BRIEF.md
# Trigger Output Router

This block turns a shared set of single-cycle trigger pulses into several independent trigger outputs. Eight pulse inputs come from the packet receiver, the energy detector, the AGC-done flag, a register-write strobe and four external pins. Six outputs feed the baseband capture buffer, the AGC start line and four external pins.

Each output has its own settings: which inputs it listens to, whether any one of them or all of them together are needed, a delay in clock cycles, and a sticky mode. In sticky mode a fired output stays high until software clears it, so a filled capture buffer is not overwritten by a later event. Outside sticky mode each trigger becomes a one-cycle pulse. The delay lets nodes that see a trigger at different times line up their actions. The block is meant for a 160 MHz clock domain.

Input bit positions: 0 packet, 1 energy, 2 AGC done, 3 register write, 4 to 7 external pins. Output bit positions: 0 baseband buffer, 1 AGC start, 2 to 5 external pins.

Top module: `trig_router`

## Requirements
- R1: While `rst_n` is low, and after it is released with no trigger, every output is low and no delay is pending.
- R2: When bit j of `cfg_all` is 0, output j fires when at least one input selected by its mask (`cfg_mask[j*8 +: 8]`, bit i selects input i) pulses.
- R3: When bit j of `cfg_all` is 1, output j fires only when every input selected by its mask pulses in the same cycle; a partial set has no effect.
- R4: An output whose mask is all zeros never fires, in either combine mode.
- R5: With `cfg_hold[j]` low and zero delay, a trigger sampled at a clock edge drives output j high for exactly the following cycle.
- R6: With delay d (`cfg_delay[j*8 +: 8]`, 0 to 255 cycles), the output rises d cycles later than it would with zero delay.
- R7: While a delay is pending on an output, further triggers for that output are ignored; once the delayed pulse has been issued, a new trigger is accepted.
- R8: With `cfg_hold[j]` high, output j stays high after firing until a clear pulse on `clr[j]`, and is low in the cycle after that clear.
- R9: A clear arriving in the same cycle as a fire leaves the output low.
- R10: Each output acts only on its own settings; one input can drive several outputs with different delays.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 8 | Single-cycle trigger pulses, one bit per source |
| cfg_mask | input | 48 | Input selection mask, 8 bits per output |
| cfg_all | input | 6 | Combine mode per output: 0 any, 1 all |
| cfg_hold | input | 6 | Sticky mode enable per output |
| cfg_delay | input | 48 | Delay in cycles, 8 bits per output |
| clr | input | 6 | Clear pulse per output for sticky mode |
| trig_out | output | 6 | Trigger outputs |

## Verification
The combine logic is tried with a single selected input in any-mode, with a partial and then a full set of selected inputs in all-mode, and with every input pulsing against an empty mask; these separate a working any/all choice from one that ignores the mode or treats an empty mask as all-satisfied. Delay is tried at one and five cycles, with a second trigger landing inside the pending window and another arriving after it, which tells a single-pending counter apart from one that restarts or queues. Sticky outputs are held over several cycles, then cleared, and a clear coinciding with a fire shows the clear's priority. One input feeding two outputs with different delays shows that per-output state does not leak.

// File: rtl/trig_router_pkg.sv
package trig_router_pkg;
  localparam int unsigned SRC_COUNT  = 8;
  localparam int unsigned DEST_COUNT = 6;
  localparam int unsigned WAIT_BITS  = 8;

  typedef enum logic {
    COMB_ANY = 1'b0,
    COMB_ALL = 1'b1
  } comb_mode_e;
endpackage

// File: rtl/trig_match.sv
module trig_match
  import trig_router_pkg::*;
#(
  parameter int unsigned N_IN = SRC_COUNT
) (
  input  logic [N_IN-1:0] sel,
  input  logic [N_IN-1:0] pulses,
  input  comb_mode_e      mode,
  output logic            hit
);
  function automatic logic evaluate(input logic [N_IN-1:0] s,
                                    input logic [N_IN-1:0] p,
                                    input comb_mode_e m);
    logic [N_IN-1:0] seen;
    seen = s & p;
    if (s == '0) return 1'b0;
    if (m == COMB_ALL) return (seen == s);
    return (seen != '0);
  endfunction

  assign hit = evaluate(sel, pulses, mode);
endmodule

// File: rtl/trig_delay.sv
module trig_delay #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] delay,
  output logic             fire,
  output logic             busy
);
  logic [DLY_W-1:0] remain_q;
  logic             busy_q;
  logic             accept;
  logic             expire;

  function automatic logic [DLY_W-1:0] step_down(input logic [DLY_W-1:0] v);
    return v - DLY_W'(1);
  endfunction

  assign accept = start & ~busy_q;
  assign expire = busy_q & (remain_q == DLY_W'(1));
  assign fire   = expire | (accept & (delay == '0));
  assign busy   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (busy_q) begin
      remain_q <= step_down(remain_q);
      if (expire) busy_q <= 1'b0;
    end else if (accept && (delay != '0)) begin
      busy_q   <= 1'b1;
      remain_q <= delay;
    end
  end
endmodule

// File: rtl/trig_latch.sv
module trig_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic hold,
  input  logic clr,
  output logic q
);
  logic q_next;

  always_comb begin
    if (clr) q_next = 1'b0;
    else     q_next = fire | (hold & q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end
endmodule

// File: rtl/trig_router.sv
module trig_router
  import trig_router_pkg::*;
#(
  parameter int unsigned N_IN  = SRC_COUNT,
  parameter int unsigned N_OUT = DEST_COUNT,
  parameter int unsigned DLY_W = WAIT_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        trig_in,
  input  logic [N_OUT*N_IN-1:0]  cfg_mask,
  input  logic [N_OUT-1:0]       cfg_all,
  input  logic [N_OUT-1:0]       cfg_hold,
  input  logic [N_OUT*DLY_W-1:0] cfg_delay,
  input  logic [N_OUT-1:0]       clr,
  output logic [N_OUT-1:0]       trig_out
);
  logic [N_OUT-1:0] match_w;
  logic [N_OUT-1:0] fire_w;
  logic [N_OUT-1:0] busy_w;

  for (genvar j = 0; j < N_OUT; j++) begin : g_dest
    trig_match #(.N_IN(N_IN)) u_match (
      .sel    (cfg_mask[j*N_IN +: N_IN]),
      .pulses (trig_in),
      .mode   (comb_mode_e'(cfg_all[j])),
      .hit    (match_w[j])
    );

    trig_delay #(.DLY_W(DLY_W)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .start (match_w[j]),
      .delay (cfg_delay[j*DLY_W +: DLY_W]),
      .fire  (fire_w[j]),
      .busy  (busy_w[j])
    );

    trig_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire_w[j]),
      .hold  (cfg_hold[j]),
      .clr   (clr[j]),
      .q     (trig_out[j])
    );
  end
endmodule

// File: rtl/trig_router_chk.sv
module trig_router_chk #(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned N_OUT = 6,
  parameter int unsigned DLY_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_OUT*N_IN-1:0]  cfg_mask,
  input logic [N_OUT-1:0]       cfg_hold,
  input logic [N_OUT*DLY_W-1:0] cfg_delay,
  input logic [N_OUT-1:0]       clr,
  input logic [N_OUT-1:0]       trig_out,
  input logic [N_OUT-1:0]       match_w,
  input logic [N_OUT-1:0]       fire_w,
  input logic [N_OUT-1:0]       busy_w
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    assert_empty_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mask[i*N_IN +: N_IN] == '0) |-> !match_w[i]);

    assert_pulse_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_hold[i] && !fire_w[i]) |=> !trig_out[i]);

    assert_delay_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_w[i] && match_w[i] && (cfg_delay[i*DLY_W +: DLY_W] != '0)) |=> busy_w[i]);

    assert_pending_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w[i] && !fire_w[i]) |=> busy_w[i]);

    assert_pending_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w[i] && fire_w[i]) |=> !busy_w[i]);

    assert_hold_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hold[i] && trig_out[i] && !clr[i]) |=> trig_out[i]);

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !trig_out[i]);
  end
endmodule

bind trig_router trig_router_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_mask  (cfg_mask),
  .cfg_hold  (cfg_hold),
  .cfg_delay (cfg_delay),
  .clr       (clr),
  .trig_out  (trig_out),
  .match_w   (match_w),
  .fire_w    (fire_w),
  .busy_w    (busy_w)
);

// File: tb/trig_router_bench.sv
`timescale 1ns/1ps
module trig_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_in = '0;
  logic [47:0] cfg_mask = '0;
  logic [5:0]  cfg_all = '0;
  logic [5:0]  cfg_hold = '0;
  logic [47:0] cfg_delay = '0;
  logic [5:0]  clr = '0;
  logic [5:0]  trig_out;

  int checks = 0;
  int fails  = 0;
  logic [5:0] trace [0:15];

  always #2 clk = ~clk;

  trig_router u_trig_router (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_mask(cfg_mask),
    .cfg_all(cfg_all), .cfg_hold(cfg_hold), .cfg_delay(cfg_delay),
    .clr(clr), .trig_out(trig_out)
  );

  task automatic wipe_cfg();
    cfg_mask = '0; cfg_all = '0; cfg_hold = '0; cfg_delay = '0;
    clr = '0; trig_in = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_out(int j, logic [7:0] m, logic all, logic hold, logic [7:0] d);
    cfg_mask[j*8 +: 8]  = m;
    cfg_all[j]          = all;
    cfg_hold[j]         = hold;
    cfg_delay[j*8 +: 8] = d;
  endtask

  // v1/clrv take effect at edge E0; v2 is applied at edge E(k2+1); trace[k] holds outputs after E(k)
  task automatic run(logic [7:0] v1, logic [5:0] clrv, logic [7:0] v2, int k2, int n);
    @(negedge clk);
    trig_in = v1; clr = clrv;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      trace[k] = trig_out;
      trig_in = (k == k2) ? v2 : '0;
      clr = '0;
    end
    trig_in = '0;
  endtask

  task automatic expect_train(int idx, int n, logic [31:0] exp, string tag);
    for (int k = 0; k < n; k++) begin
      checks++;
      if (trace[k][idx] !== exp[k]) begin
        fails++;
        $display("FAIL %s out%0d cycle %0d: actual %b expected %b", tag, idx, k, trace[k][idx], exp[k]);
      end
    end
  endtask

  task automatic check_vec(logic [5:0] exp, string tag);
    checks++;
    if (trig_out !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, trig_out, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); check_vec(6'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk); check_vec(6'b0, "R1 after reset");
  endtask

  task automatic t_or();
    wipe_cfg();
    set_out(0, 8'b0001_0001, 1'b0, 1'b0, 8'd0);
    run(8'b0001_0000, '0, '0, -1, 3);
    expect_train(0, 3, 32'b001, "R2 any-mode");
    expect_train(1, 3, 32'b000, "R10 untouched output");
  endtask

  task automatic t_and();
    wipe_cfg();
    set_out(1, 8'b0000_0110, 1'b1, 1'b0, 8'd0);
    run(8'b0000_0010, '0, '0, -1, 3);
    expect_train(1, 3, 32'b000, "R3 partial set");
    run(8'b0000_0110, '0, '0, -1, 3);
    expect_train(1, 3, 32'b001, "R3 full set");
  endtask

  task automatic t_empty();
    wipe_cfg();
    set_out(2, 8'h00, 1'b1, 1'b0, 8'd0);
    set_out(5, 8'h00, 1'b0, 1'b0, 8'd0);
    run(8'hFF, '0, 8'hFF, 0, 3);
    expect_train(2, 3, 32'b000, "R4 empty mask all-mode");
    expect_train(5, 3, 32'b000, "R4 empty mask any-mode");
  endtask

  task automatic t_hold();
    wipe_cfg();
    set_out(3, 8'b0010_0000, 1'b0, 1'b1, 8'd0);
    run(8'b0010_0000, '0, '0, -1, 5);
    expect_train(3, 5, 32'b11111, "R8 held high");
    run(8'h00, 6'b00_1000, '0, -1, 3);
    expect_train(3, 3, 32'b000, "R8 cleared");
    run(8'b0010_0000, 6'b00_1000, '0, -1, 3);
    expect_train(3, 3, 32'b000, "R9 clear beats fire");
  endtask

  task automatic t_pulse();
    wipe_cfg();
    set_out(4, 8'b1000_0000, 1'b0, 1'b0, 8'd0);
    run(8'b1000_0000, '0, 8'b1000_0000, 0, 4);
    expect_train(4, 4, 32'b0011, "R5 back-to-back pulses");
  endtask

  task automatic t_delay();
    wipe_cfg();
    set_out(4, 8'b0100_0000, 1'b0, 1'b0, 8'd5);
    run(8'b0100_0000, '0, '0, -1, 8);
    expect_train(4, 8, 32'b0010_0000, "R6 delay 5");
    set_out(4, 8'b0100_0000, 1'b0, 1'b0, 8'd1);
    run(8'b0100_0000, '0, '0, -1, 4);
    expect_train(4, 4, 32'b0010, "R6 delay 1");
  endtask

  task automatic t_pending();
    wipe_cfg();
    set_out(4, 8'b0100_0000, 1'b0, 1'b0, 8'd5);
    run(8'b0100_0000, '0, 8'b0100_0000, 1, 10);
    expect_train(4, 10, 32'b00_0010_0000, "R7 retrigger ignored");
    run(8'b0100_0000, '0, 8'b0100_0000, 5, 13);
    expect_train(4, 13, 32'b0_1000_0010_0000, "R7 retrigger after pulse");
  endtask

  task automatic t_independent();
    wipe_cfg();
    set_out(0, 8'b1000_0000, 1'b0, 1'b0, 8'd0);
    set_out(5, 8'b1000_0000, 1'b0, 1'b0, 8'd3);
    run(8'b1000_0000, '0, '0, -1, 6);
    expect_train(0, 6, 32'b00_0001, "R10 zero-delay output");
    expect_train(5, 6, 32'b00_1000, "R10 delayed output");
    expect_train(1, 6, 32'b00_0000, "R10 unselected output");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_or();
    t_and();
    t_empty();
    t_hold();
    t_pulse();
    t_delay();
    t_pending();
    t_independent();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule